// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block runs the complete programming flow for a byte-wide one-time-programmable memory. After a start pulse it raises the core supply, then the programming supply. It gives every address, from the lowest upward, a single unverified program pulse. It then returns to the lowest address for a verify pass. In that pass a byte that reads back wrong is pulsed again, one pulse at a time, with a read after each pulse. The number of extra pulses per byte is bounded. Once the verify pass is over, the programming supply is lowered and then the core supply. The whole array is then read at normal levels and compared with the expected data, which gives the final verdict.

The expected byte comes from a data source addressed by the sequencer's current address. Pulses and reads are carried out by a separate per-byte cycle engine, which receives a held request and answers with a one-cycle acknowledge. The engine owns all pin timing. Two level outputs select programming or normal level for each supply. Every change of supply level is followed by a fixed settle wait before the next operation. The result stays on the outputs until the next start: a done flag, a pass flag, the failing address and the number of extra pulses that had been spent on it.

The state machine has ten named states:
- IDLE: waits for start.
- RAISE_CORE: core supply high, settle wait.
- RAISE_PP: programming supply high, settle wait.
- P1_PULSE: one pulse per address.
- P2_READ: verify read.
- P2_PULSE: extra pulse.
- DROP_PP: programming supply low, settle wait.
- DROP_CORE: core supply low, settle wait.
- FINAL_READ: compare at normal level.
- FINISH: result held.

Its transitions are:
- start: IDLE or FINISH to RAISE_CORE.
- settle done: RAISE_CORE to RAISE_PP, RAISE_PP to P1_PULSE, DROP_PP to DROP_CORE.
- settle done: DROP_CORE to FINAL_READ, or to FINISH when a programming failure is already recorded.
- acknowledge on the last address: P1_PULSE to P2_READ.
- read match on the last address: P2_READ to DROP_PP.
- read mismatch with retries left: P2_READ to P2_PULSE.
- read mismatch with no retries left: P2_READ to DROP_PP, recording the failure.
- acknowledge: P2_PULSE back to P2_READ.
- mismatch, or match on the last address: FINAL_READ to FINISH.
- asynchronous reset: any state to IDLE.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, and while idle with no start, vcore_hi, vpp_hi, op_req and done are all 0. An asynchronous reset in the middle of a run clears all four at once.
- R2: vpp_hi is never 1 while vcore_hi is 0. On start, vcore_hi rises first. vpp_hi rises exactly SETTLE_CYC cycles later, and the first request comes SETTLE_CYC cycles after that. On shutdown, vpp_hi falls first and vcore_hi falls exactly SETTLE_CYC cycles later.
- R3: The first pass issues exactly one pulse (op_kind = 1) to each address in ascending order from address 0, with no read (op_kind = 0) in between.
- R4: In the second pass each address is read. A mismatch against exp_data causes one pulse and then a new read of the same address. A match moves on to the next address. The total pulse count is therefore the array depth plus the extra pulses the bytes needed.
- R5: At most MAX_RETRY (10) extra pulses are given to one byte. A byte that needs exactly 10 still passes. A mismatch after the tenth extra pulse ends the run failed, with fail_addr set to that address and fail_retries set to 10. The supplies are then lowered and no final read is made.
- R6: The final pass reads every address while both supplies are at normal level (vcore_hi = 0). If all bytes match, pass is 1. On the first mismatch the run stops, with fail_addr set to that address and fail_retries set to 0.
- R7: At the end of a run, done is held at 1 with both supplies low until the next start. A new start begins a fresh run, and the previous result does not affect it.
- R8: op_req stays asserted with a stable op_addr and op_kind until op_ack. On a pulse, op_wdata equals exp_data for op_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or finished |
| cur_addr | output | ADDR_W | Current address, shared by the data source and the cycle engine |
| exp_data | input | DATA_W | Expected byte at cur_addr |
| vcore_hi | output | 1 | 1 = core supply at programming level |
| vpp_hi | output | 1 | 1 = programming supply at programming level |
| op_req | output | 1 | Operation request to the cycle engine |
| op_kind | output | 1 | 1 = program pulse, 0 = read |
| op_wdata | output | DATA_W | Byte to program |
| op_ack | input | 1 | One-cycle completion from the cycle engine |
| op_rdata | input | DATA_W | Read data, valid with op_ack |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Run passed (valid with done) |
| fail_addr | output | ADDR_W | Address that failed |
| fail_retries | output | RETRY_W | Extra pulses spent on the failing byte |

## Verification
A wrong state or a skipped transition shows at the supply outputs or in the operation stream within one settle window or one handshake. Examples are a supply raised out of order, a settle wait of the wrong length, a read issued in the first pass, or a pulse sent when the programming supply is low. A miscounted retry or address counter shows only at the end of the run. It appears as a total pulse count, final-read count or latched failure field that differs from the value worked out from each scenario's per-byte pulse needs. Each scenario therefore checks both the stream and the end result.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAISE_CORE,
        ST_RAISE_PP,
        ST_P1_PULSE,
        ST_P2_READ,
        ST_P2_PULSE,
        ST_DROP_PP,
        ST_DROP_CORE,
        ST_FINAL_READ,
        ST_FINISH
    } seq_state_t;

    localparam logic OP_READ  = 1'b0;
    localparam logic OP_PULSE = 1'b1;
endpackage

// File: rtl/otp_step_ctr.sv
module otp_step_ctr #(
    parameter int W     = 4,
    parameter int LIMIT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_limit
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LIM);
endmodule

// File: rtl/otp_settle_tmr.sv
module otp_settle_tmr #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] END_CNT = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (cnt != END_CNT) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == END_CNT);
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
    import otp_burn_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int MAX_RETRY  = 10,
    parameter int RETRY_W    = 4,
    parameter int SETTLE_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [ADDR_W-1:0]  cur_addr,
    input  logic [DATA_W-1:0]  exp_data,
    output logic               vcore_hi,
    output logic               vpp_hi,
    output logic               op_req,
    output logic               op_kind,
    output logic [DATA_W-1:0]  op_wdata,
    input  logic               op_ack,
    input  logic [DATA_W-1:0]  op_rdata,
    output logic               done,
    output logic               pass,
    output logic [ADDR_W-1:0]  fail_addr,
    output logic [RETRY_W-1:0] fail_retries
);
    localparam int LAST_ADDR = (1 << ADDR_W) - 1;

    seq_state_t         state_q, state_d;
    logic               tmr_exp;
    logic               addr_clr, addr_inc, addr_last;
    logic               rty_clr, rty_inc, rty_max;
    logic [RETRY_W-1:0] rty_cnt;
    logic               run_clr, fail_set, pass_set;
    logic               failed_q, pass_q;
    logic               match;

    assign match = (op_rdata == exp_data);

    otp_settle_tmr #(.CYCLES(SETTLE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .restart(state_d != state_q),
        .expired(tmr_exp)
    );

    otp_step_ctr #(.W(ADDR_W), .LIMIT(LAST_ADDR)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
        .cnt(cur_addr), .at_limit(addr_last)
    );

    otp_step_ctr #(.W(RETRY_W), .LIMIT(MAX_RETRY)) u_rty (
        .clk(clk), .rst_n(rst_n), .clr(rty_clr), .inc(rty_inc),
        .cnt(rty_cnt), .at_limit(rty_max)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        run_clr  = 1'b0;
        fail_set = 1'b0;
        pass_set = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: if (start) begin
                state_d  = ST_RAISE_CORE;
                addr_clr = 1'b1;
                rty_clr  = 1'b1;
                run_clr  = 1'b1;
            end
            ST_RAISE_CORE: if (tmr_exp) state_d = ST_RAISE_PP;
            ST_RAISE_PP:   if (tmr_exp) state_d = ST_P1_PULSE;
            ST_P1_PULSE: if (op_ack) begin
                if (addr_last) begin
                    state_d  = ST_P2_READ;
                    addr_clr = 1'b1;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_P2_READ: if (op_ack) begin
                if (match) begin
                    rty_clr = 1'b1;
                    if (addr_last) begin
                        state_d  = ST_DROP_PP;
                        addr_clr = 1'b1;
                    end else begin
                        addr_inc = 1'b1;
                    end
                end else if (rty_max) begin
                    fail_set = 1'b1;
                    state_d  = ST_DROP_PP;
                    addr_clr = 1'b1;
                    rty_clr  = 1'b1;
                end else begin
                    state_d = ST_P2_PULSE;
                end
            end
            ST_P2_PULSE: if (op_ack) begin
                rty_inc = 1'b1;
                state_d = ST_P2_READ;
            end
            ST_DROP_PP:   if (tmr_exp) state_d = ST_DROP_CORE;
            ST_DROP_CORE: if (tmr_exp) state_d = failed_q ? ST_FINISH : ST_FINAL_READ;
            ST_FINAL_READ: if (op_ack) begin
                if (!match) begin
                    fail_set = 1'b1;
                    state_d  = ST_FINISH;
                end else if (addr_last) begin
                    pass_set = 1'b1;
                    state_d  = ST_FINISH;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            failed_q     <= 1'b0;
            pass_q       <= 1'b0;
            fail_addr    <= '0;
            fail_retries <= '0;
        end else if (run_clr) begin
            failed_q     <= 1'b0;
            pass_q       <= 1'b0;
            fail_addr    <= '0;
            fail_retries <= '0;
        end else if (fail_set) begin
            failed_q     <= 1'b1;
            fail_addr    <= cur_addr;
            fail_retries <= rty_cnt;
        end else if (pass_set) begin
            pass_q <= 1'b1;
        end
    end

    always_comb begin
        vcore_hi = 1'b0;
        vpp_hi   = 1'b0;
        op_req   = 1'b0;
        op_kind  = OP_READ;
        done     = 1'b0;
        unique case (state_q)
            ST_RAISE_CORE: vcore_hi = 1'b1;
            ST_RAISE_PP:   begin vcore_hi = 1'b1; vpp_hi = 1'b1; end
            ST_P1_PULSE, ST_P2_PULSE: begin
                vcore_hi = 1'b1; vpp_hi = 1'b1; op_req = 1'b1; op_kind = OP_PULSE;
            end
            ST_P2_READ:    begin vcore_hi = 1'b1; vpp_hi = 1'b1; op_req = 1'b1; end
            ST_DROP_PP:    vcore_hi = 1'b1;
            ST_FINAL_READ: op_req = 1'b1;
            ST_FINISH:     done = 1'b1;
            default:       ;
        endcase
    end

    assign op_wdata = exp_data;
    assign pass     = pass_q;
endmodule

// File: rtl/otp_burn_chk.sv
module otp_burn_chk #(
    parameter int ADDR_W    = 15,
    parameter int RETRY_W   = 4,
    parameter int MAX_RETRY = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vcore_hi,
    input logic               vpp_hi,
    input logic               op_req,
    input logic               op_kind,
    input logic               op_ack,
    input logic [ADDR_W-1:0]  cur_addr,
    input logic               done,
    input logic [RETRY_W-1:0] rty_cnt
);
    AST_SUPPLY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hi |-> vcore_hi); // R2

    AST_PP_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_hi) |-> $past(vcore_hi)); // R2

    AST_PULSE_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_kind) |-> (vpp_hi && vcore_hi)); // R3

    AST_FINAL_AT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !vcore_hi) |-> !op_kind); // R6

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rty_cnt <= RETRY_W'(MAX_RETRY)); // R5

    AST_DONE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vcore_hi && !vpp_hi && !op_req)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> (op_req && $stable(cur_addr) && $stable(op_kind))); // R8
endmodule

bind otp_burn_seq otp_burn_chk #(
    .ADDR_W(ADDR_W), .RETRY_W(RETRY_W), .MAX_RETRY(MAX_RETRY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vcore_hi(vcore_hi), .vpp_hi(vpp_hi),
    .op_req(op_req), .op_kind(op_kind), .op_ack(op_ack),
    .cur_addr(cur_addr), .done(done), .rty_cnt(rty_cnt)
);

// File: tb/otp_burn_seq_bench.sv
module otp_burn_seq_bench;
    localparam int AW     = 3;
    localparam int DW     = 8;
    localparam int RW     = 4;
    localparam int SETTLE = 5;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] exp_data;
    logic          vcore_hi, vpp_hi, op_req, op_kind, op_ack, done, pass;
    logic [DW-1:0] op_wdata, op_rdata;
    logic [AW-1:0] fail_addr;
    logic [RW-1:0] fail_retries;

    always #10 clk = ~clk;

    otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .MAX_RETRY(10), .RETRY_W(RW),
                   .SETTLE_CYC(SETTLE)) u_otp_burn_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_addr(cur_addr),
        .exp_data(exp_data), .vcore_hi(vcore_hi), .vpp_hi(vpp_hi),
        .op_req(op_req), .op_kind(op_kind), .op_wdata(op_wdata),
        .op_ack(op_ack), .op_rdata(op_rdata), .done(done), .pass(pass),
        .fail_addr(fail_addr), .fail_retries(fail_retries)
    );

    function automatic logic [DW-1:0] exp_of(input logic [AW-1:0] a);
        return 8'h10 + {5'b0, a} * 8'h11;
    endfunction
    assign exp_data = exp_of(cur_addr);

    typedef struct packed {
        logic [2:0] hot_a;
        logic [4:0] need;
        logic       leak_en;
        logic [2:0] leak_a;
        logic       exp_pass;
        logic [2:0] exp_fa;
        logic [3:0] exp_rt;
        logic [5:0] exp_pulses;
        logic [3:0] exp_fin;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 5'd1,  1'b0, 3'd0, 1'b1, 3'd0, 4'd0,  6'd8,  4'd8},
        '{3'd3, 5'd4,  1'b0, 3'd0, 1'b1, 3'd0, 4'd0,  6'd11, 4'd8},
        '{3'd7, 5'd11, 1'b0, 3'd0, 1'b1, 3'd0, 4'd0,  6'd18, 4'd8},
        '{3'd5, 5'd12, 1'b0, 3'd0, 1'b0, 3'd5, 4'd10, 6'd18, 4'd0},
        '{3'd0, 5'd1,  1'b1, 3'd6, 1'b0, 3'd6, 4'd0,  6'd8,  4'd7},
        '{3'd2, 5'd2,  1'b1, 3'd0, 1'b0, 3'd0, 4'd0,  6'd9,  4'd1}
    };

    int checks = 0, fails = 0;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // memory and cycle-engine model
    logic [DW-1:0] mem  [DEPTH];
    int            need [DEPTH];
    logic          leak_en;
    logic [AW-1:0] leak_a;
    int pulses, fin_reads, hv_viol, wdata_err, p1_err, p1_next, reads_seen;

    initial begin
        int lat;
        lat = 0; op_ack = 1'b0; op_rdata = '0;
        forever begin
            @(negedge clk);
            if (op_ack) begin
                op_ack = 1'b0;
                lat = 0;
            end else if (op_req && rst_n) begin
                if (lat == 1) begin
                    if (op_kind) begin
                        pulses++;
                        if (!(vcore_hi && vpp_hi)) hv_viol++;
                        if (op_wdata != exp_of(cur_addr)) wdata_err++;
                        if (reads_seen == 0) begin
                            if (int'(cur_addr) != p1_next) p1_err++;
                            p1_next++;
                        end
                        if (need[cur_addr] > 0) begin
                            need[cur_addr]--;
                            if (need[cur_addr] == 0) mem[cur_addr] = op_wdata;
                        end
                    end else begin
                        reads_seen++;
                        op_rdata = mem[cur_addr];
                        if (!vcore_hi) begin
                            fin_reads++;
                            if (leak_en && cur_addr == leak_a) op_rdata = op_rdata ^ 8'h01;
                        end
                    end
                    op_ack = 1'b1;
                end else begin
                    lat++;
                end
            end else begin
                lat = 0;
            end
        end
    end

    // supply timing monitor
    int cyc = 0, t_core_up, t_pp_up, t_req1, t_pp_dn, t_core_dn, order_viol;
    logic pv_core = 1'b0, pv_pp = 1'b0, seen_req;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (vpp_hi && !vcore_hi) order_viol++;
            if (vcore_hi && !pv_core) t_core_up = cyc;
            if (!vcore_hi && pv_core) t_core_dn = cyc;
            if (vpp_hi && !pv_pp) t_pp_up = cyc;
            if (!vpp_hi && pv_pp) t_pp_dn = cyc;
            if (op_req && !seen_req) begin t_req1 = cyc; seen_req = 1'b1; end
            pv_core = vcore_hi;
            pv_pp   = vpp_hi;
        end
    end

    task automatic prep(input vec_t v);
        for (int a = 0; a < DEPTH; a++) begin
            mem[a]  = 8'hFF;
            need[a] = (a == int'(v.hot_a)) ? int'(v.need) : 1;
        end
        leak_en = v.leak_en; leak_a = v.leak_a;
        pulses = 0; fin_reads = 0; hv_viol = 0; wdata_err = 0;
        p1_err = 0; p1_next = 0; reads_seen = 0; order_viol = 0;
        seen_req = 1'b0;
    endtask

    task automatic run_and_wait();
        int guard;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        check("R7 done reached", int'(done), 1);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        prep(VECS[0]);
        repeat (3) @(negedge clk);
        check("R1 reset vcore_hi", int'(vcore_hi), 0);
        check("R1 reset vpp_hi", int'(vpp_hi), 0);
        check("R1 reset op_req", int'(op_req), 0);
        check("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 idle no supply", int'(vcore_hi | vpp_hi | op_req | done), 0);

        for (int i = 0; i < NV; i++) begin
            prep(VECS[i]);
            run_and_wait();
            check("R7 pass flag", int'(pass), int'(VECS[i].exp_pass));
            check("R7 supplies low at done", int'(vcore_hi | vpp_hi), 0);
            if (!VECS[i].exp_pass) begin
                check("R5 R6 fail_addr", int'(fail_addr), int'(VECS[i].exp_fa));
                check("R5 R6 fail_retries", int'(fail_retries), int'(VECS[i].exp_rt));
            end
            check("R4 total pulses", pulses, int'(VECS[i].exp_pulses));
            check("R6 final reads", fin_reads, int'(VECS[i].exp_fin));
            check("R3 first pass order", p1_err, 0);
            check("R3 first pass count", p1_next, DEPTH);
            check("R2 pulse at high level", hv_viol, 0);
            check("R2 supply order", order_viol, 0);
            check("R2 pp rise delay", t_pp_up - t_core_up, SETTLE);
            check("R2 first request delay", t_req1 - t_pp_up, SETTLE);
            check("R2 core fall delay", t_core_dn - t_pp_dn, SETTLE);
            check("R8 write data", wdata_err, 0);
        end

        // R7: done held across idle cycles
        repeat (10) @(negedge clk);
        check("R7 done held", int'(done), 1);

        // R1: reset in the middle of the programming pass
        prep(VECS[1]);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2 * SETTLE + 6) @(negedge clk);
        check("R1 mid-run in programming", int'(vpp_hi), 1);
        #3 rst_n = 1'b0;
        #2;
        check("R1 mid-run reset vcore_hi", int'(vcore_hi), 0);
        check("R1 mid-run reset vpp_hi", int'(vpp_hi), 0);
        check("R1 mid-run reset op_req", int'(op_req), 0);
        @(negedge clk); rst_n = 1'b1;

        // restart after reset still completes cleanly
        prep(VECS[0]);
        run_and_wait();
        check("R7 pass after reset", int'(pass), 1);
        check("R4 pulses after reset", pulses, DEPTH);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule